// File: doc/BRIEF.md
# Quad DAC serial register front-end

This block is the digital side of a four-channel, 16-bit digital-to-analog converter. A host shifts 32-bit command frames in over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block samples data on falling serial-clock edges, most significant bit first. Once a frame is complete it decodes it and writes one channel's input register, or all four, or the clear-code setting. The serial pins are oversampled by the system clock `clk`. They must be synchronous to it and stay stable for at least two `clk` cycles per level.

Each channel has two register tiers. The input tier takes new data from frames. The output tier drives `dac_q`, which feeds the converters. An active-low load input moves every channel that holds unloaded data into its output tier in one cycle, so all outputs change together. A falling edge on the active-low clear input forces both tiers to a programmable clear value. The serial link has no back-pressure: every complete frame is acted on in the cycle after its last bit, and the block can never refuse one.

Top module: `qdac_front`

## Requirements
- R1: A frame begins while `frm_n` is low. Bits are taken on `sck` falling edges, first bit as bit 31. The frame is accepted at the 32nd falling edge, and any further falling edges before `frm_n` rises are ignored.
- R2: Field positions within a frame: command in bits 27:24, channel address in bits 23:20, data in bits 19:4. Bits 31:28 and 3:0 carry no meaning.
- R3: If `frm_n` rises before the 32nd falling edge, the frame is dropped and no register changes.
- R4: Command 0x0 writes the addressed input register only. `dac_q` does not change while `ld_n` stays high.
- R5: While `ld_n` is low and `clr_n` is high, every channel whose input register was written since its last transfer copies it to its output in the same cycle. Other channels keep their value.
- R6: Command 0x2 writes the addressed input register and, in the same cycle, moves every channel's input register (including the new data) to its output.
- R7: Address 0xF selects all four channels. Addresses 4 to 14 write nothing. Commands other than 0x0, 0x2 and 0x5 change nothing.
- R8: With `ld_n` held low, a channel's output follows a command 0x0 write one `clk` cycle after the input register takes it.
- R9: During reset (`rst_n` low), both tiers of every channel take 0x0000 when `por_mid` is low and 0x8000 when it is high.
- R10: A falling edge on `clr_n` loads both tiers of every channel with the clear value. Command 0x5 picks that value from data bits 1:0: 00 gives 0x0000, 01 gives 0x8000, 10 gives 0xFFFF, and 11 is ignored. The setting resets to 00.
- R11: While `clr_n` is low, `ld_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_mid | input | 1 | Reset value select: 0 gives zero, 1 gives midscale |
| frm_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock; data taken on falling edges |
| sdi | input | 1 | Serial data, MSB first |
| ld_n | input | 1 | Active-low load of pending channels |
| clr_n | input | 1 | Clear, acts on falling edge; blocks load while low |
| dac_q | output | 64 | Output tier, channel 0 in bits 15:0 up to channel 3 in bits 63:48 |

## Verification
A wrong bit count or a stuck frame counter shows up as a missing or shifted data word in `dac_q`. This appears as soon as the next load, no more than a few cycles after the frame. A pending flag that fails to set or clear shows only when a later load pulse runs, because a channel then moves when it should hold or holds when it should move. For that reason every write is followed by a load and a full check of all four channels. Input registers are never visible directly. A bad clear of the input tier is therefore caught through a following command 0x2, which pushes every channel's input register out to `dac_q`.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_W = 32;
  localparam int DAT_W   = 16;
  localparam int CMD_LO  = 24;
  localparam int ADR_LO  = 20;
  localparam int DAT_LO  = 4;

  localparam logic [3:0] ADR_ALL = 4'hF;

  typedef enum logic [3:0] {
    OP_WR    = 4'h0,
    OP_WRUPD = 4'h2,
    OP_CCODE = 4'h5
  } op_e;

  typedef enum logic [1:0] {
    CC_ZERO = 2'b00,
    CC_MID  = 2'b01,
    CC_FULL = 2'b10,
    CC_BAD  = 2'b11
  } ccode_e;
endpackage

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_n,
  input  logic          sck,
  input  logic          sdi,
  output logic          word_vld,
  output logic [FW-1:0] word
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);
  localparam logic [CW-1:0] FULL = CW'(FW);

  logic          sck_q;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sh;
  logic          fall;

  assign fall = sck_q & ~sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      sck_q    <= sck;
      word_vld <= 1'b0;
      if (frm_n) begin
        cnt <= '0;
      end else if (fall && cnt < FULL) begin
        sh  <= {sh[FW-2:0], sdi};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          word_vld <= 1'b1;
          word     <= {sh[FW-2:0], sdi};
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL) else $error("bit count past frame length"); // R1

  AST_FRAME_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> ($past(!frm_n) && $past(cnt) == LAST)) else $error("frame without full select"); // R3

  AST_ABORT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |=> (cnt == '0)) else $error("count survives select high"); // R3
endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               word_vld,
  input  logic [FRAME_W-1:0] word,
  output logic [NCH-1:0]     wr_mask,
  output logic [DAT_W-1:0]   wr_data,
  output logic               upd_all,
  output logic               cc_we,
  output logic [1:0]         cc_val
);
  logic [3:0] op;
  logic [3:0] adr;
  logic       is_wr;
  logic       unused_bits;

  assign op          = word[CMD_LO +: 4];
  assign adr         = word[ADR_LO +: 4];
  assign wr_data     = word[DAT_LO +: DAT_W];
  assign unused_bits = ^{word[FRAME_W-1:CMD_LO+4], word[DAT_LO-1:0]};

  assign is_wr   = (op == OP_WR) || (op == OP_WRUPD);
  assign upd_all = word_vld && (op == OP_WRUPD);
  assign cc_val  = wr_data[1:0];
  assign cc_we   = word_vld && (op == OP_CCODE) && (cc_val != CC_BAD);

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    assign wr_mask[g] = word_vld && is_wr && (adr == ADR_ALL || adr == 4'(g));
  end
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_mid,
  input  logic                 ld_n,
  input  logic                 clr_n,
  input  logic [NCH-1:0]       wr_mask,
  input  logic [DAT_W-1:0]     wr_data,
  input  logic                 upd_all,
  input  logic                 cc_we,
  input  logic [1:0]           cc_val,
  output logic [NCH*DAT_W-1:0] dac_q
);
  localparam logic [DAT_W-1:0] MID = {1'b1, {(DAT_W-1){1'b0}}};

  logic [DAT_W-1:0] rst_val;
  logic [DAT_W-1:0] clr_val;
  logic [1:0]       ccode;
  logic             clr_q;
  logic             clr_fall;
  logic             ld_go;
  logic [NCH-1:0]   pend_v;

  assign rst_val  = por_mid ? MID : '0;
  assign clr_fall = clr_q & ~clr_n;
  assign ld_go    = ~ld_n & clr_n;

  always_comb begin
    case (ccode)
      CC_MID:  clr_val = MID;
      CC_FULL: clr_val = '1;
      default: clr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccode <= CC_ZERO;
      clr_q <= 1'b1;
    end else begin
      clr_q <= clr_n;
      if (cc_we) ccode <= cc_val;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DAT_W-1:0] inr;
    logic [DAT_W-1:0] outr;
    logic             pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inr  <= rst_val;
        outr <= rst_val;
        pend <= 1'b0;
      end else if (clr_fall) begin
        inr  <= clr_val;
        outr <= clr_val;
        pend <= 1'b0;
      end else begin
        if (wr_mask[g]) inr <= wr_data;
        if (upd_all) begin
          outr <= wr_mask[g] ? wr_data : inr;
          pend <= 1'b0;
        end else if (ld_go && pend) begin
          outr <= inr;
          pend <= wr_mask[g];
        end else if (wr_mask[g]) begin
          pend <= 1'b1;
        end
      end
    end

    assign dac_q[g*DAT_W +: DAT_W] = outr;
    assign pend_v[g]               = pend;
  end

  AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_q == {NCH{$past(clr_val)}})) else $error("clear missed outputs"); // R10

  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !clr_fall && !upd_all) |=> $stable(dac_q)) else $error("output moved during clear"); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && !clr_fall && !upd_all) |=> $stable(dac_q)) else $error("output moved without load"); // R4

  AST_LOAD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_go && !clr_fall && !upd_all && wr_mask == '0) |=> (pend_v == '0)) else $error("pending left after load"); // R5
endmodule

// File: rtl/qdac_front.sv
module qdac_front
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_mid,
  input  logic                 frm_n,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic                 ld_n,
  input  logic                 clr_n,
  output logic [NCH*DAT_W-1:0] dac_q
);
  logic               word_vld;
  logic [FRAME_W-1:0] word;
  logic [NCH-1:0]     wr_mask;
  logic [DAT_W-1:0]   wr_data;
  logic               upd_all;
  logic               cc_we;
  logic [1:0]         cc_val;

  qdac_shift #(.FW(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sck(sck), .sdi(sdi),
    .word_vld(word_vld), .word(word)
  );

  qdac_decode #(.NCH(NCH)) u_dec (
    .word_vld(word_vld), .word(word), .wr_mask(wr_mask), .wr_data(wr_data),
    .upd_all(upd_all), .cc_we(cc_we), .cc_val(cc_val)
  );

  qdac_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .ld_n(ld_n), .clr_n(clr_n),
    .wr_mask(wr_mask), .wr_data(wr_data), .upd_all(upd_all),
    .cc_we(cc_we), .cc_val(cc_val), .dac_q(dac_q)
  );
endmodule

// File: tb/test_qdac_front.sv
module test_qdac_front;
  logic        clk = 1'b0;
  logic        rst_n, por_mid, frm_n, sck, sdi, ld_n, clr_n;
  logic [63:0] dac_q;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  qdac_front i_qdac_front (
    .clk(clk), .rst_n(rst_n), .por_mid(por_mid), .frm_n(frm_n), .sck(sck),
    .sdi(sdi), .ld_n(ld_n), .clr_n(clr_n), .dac_q(dac_q)
  );

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] adr,
                                     input logic [15:0] d);
    return {4'hA, op, adr, d, 4'h5};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int ch, input logic [15:0] e, input string r);
    logic [15:0] a;
    a = dac_q[ch*16 +: 16];
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s ch%0d actual=%h expected=%h", r, ch, a, e);
    end
  endtask

  task automatic chk4(input logic [15:0] e0, input logic [15:0] e1,
                      input logic [15:0] e2, input logic [15:0] e3, input string r);
    chk(0, e0, r); chk(1, e1, r); chk(2, e2, r); chk(3, e3, r);
  endtask

  task automatic send(input logic [31:0] w, input int n);
    frm_n = 1'b0;
    tick(2);
    for (int i = 0; i < n; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'b1;
      sck = 1'b1; tick(2);
      sck = 1'b0; tick(2);
    end
    sck = 1'b1; tick(1);
    frm_n = 1'b1;
    tick(4);
  endtask

  task automatic load();
    ld_n = 1'b0; tick(2);
    ld_n = 1'b1; tick(2);
  endtask

  task automatic clr_pulse();
    clr_n = 1'b0; tick(3);
    clr_n = 1'b1; tick(2);
  endtask

  task automatic do_reset(input logic mid);
    por_mid = mid; rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(2);
  endtask

  task automatic t_reset_zero();
    do_reset(1'b0);
    chk4(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R9 zero");
  endtask

  task automatic t_write_load();
    send(mk(4'h0, 4'h1, 16'h1234), 32);
    chk4(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R4 hold");
    load();
    chk4(16'h0000, 16'h1234, 16'h0000, 16'h0000, "R5 R2 R1 load");
  endtask

  task automatic t_abort();
    send(mk(4'h2, 4'h0, 16'hAAAA), 20);
    load();
    chk4(16'h0000, 16'h1234, 16'h0000, 16'h0000, "R3 abort");
  endtask

  task automatic t_update();
    send(mk(4'h0, 4'h0, 16'h1111), 32);
    send(mk(4'h2, 4'h2, 16'hBEEF), 32);
    chk4(16'h1111, 16'h1234, 16'hBEEF, 16'h0000, "R6 update");
  endtask

  task automatic t_broadcast();
    send(mk(4'h0, 4'hF, 16'h5555), 32);
    chk4(16'h1111, 16'h1234, 16'hBEEF, 16'h0000, "R7 bcast hold");
    load();
    chk4(16'h5555, 16'h5555, 16'h5555, 16'h5555, "R7 bcast");
  endtask

  task automatic t_ignored();
    send(mk(4'h0, 4'h7, 16'h9999), 32);
    send(mk(4'h3, 4'h1, 16'h9999), 32);
    load();
    chk4(16'h5555, 16'h5555, 16'h5555, 16'h5555, "R7 ignored");
  endtask

  task automatic t_ld_low();
    ld_n = 1'b0;
    send(mk(4'h0, 4'h3, 16'h7777), 32);
    chk4(16'h5555, 16'h5555, 16'h5555, 16'h7777, "R8 ld low");
    ld_n = 1'b1; tick(2);
  endtask

  task automatic t_extra_edges();
    send(mk(4'h2, 4'h1, 16'h4321), 36);
    chk4(16'h5555, 16'h4321, 16'h5555, 16'h7777, "R1 extra edges");
  endtask

  task automatic t_clear();
    send(mk(4'h5, 4'h0, 16'h0002), 32);
    send(mk(4'h0, 4'h0, 16'h0101), 32);
    clr_n = 1'b0; tick(3);
    chk4(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R10 full");
    send(mk(4'h0, 4'h0, 16'h0202), 32);
    load();
    chk4(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R11 blocked");
    clr_n = 1'b1; tick(2);
    load();
    chk4(16'h0202, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5 R11 after clear");
    send(mk(4'h5, 4'h0, 16'h0001), 32);
    send(mk(4'h5, 4'h0, 16'h0003), 32);
    clr_pulse();
    chk4(16'h8000, 16'h8000, 16'h8000, 16'h8000, "R10 mid");
    send(mk(4'h2, 4'h1, 16'h0303), 32);
    chk4(16'h8000, 16'h0303, 16'h8000, 16'h8000, "R10 input tier");
  endtask

  task automatic t_reset_mid();
    do_reset(1'b1);
    chk4(16'h8000, 16'h8000, 16'h8000, 16'h8000, "R9 mid");
    clr_pulse();
    chk4(16'h0000, 16'h0000, 16'h0000, 16'h0000, "R10 default zero");
  endtask

  initial begin
    rst_n = 1'b0; por_mid = 1'b0; frm_n = 1'b1; sck = 1'b1; sdi = 1'b0;
    ld_n = 1'b1; clr_n = 1'b1;
    t_reset_zero();
    t_write_load();
    t_abort();
    t_update();
    t_broadcast();
    t_ignored();
    t_ld_low();
    t_extra_edges();
    t_clear();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule